// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and Priority-Drop Unit

This block sits between the interrupt routing fabric and one processor. Each cycle the fabric offers its single most urgent pending interrupt (ID, 8-bit priority, group). The unit applies the priority mask and checks preemption against the running priority. When the offer passes both tests it raises an interrupt request toward the processor. The processor acknowledges through one of two group-specific acknowledge ports. The acknowledge returns the interrupt ID in the same cycle, reports the activation to the fabric in the next cycle, and pushes the interrupt's group priority onto a running-priority stack.

An end-of-interrupt command on the matching group port pops that stack, which is the priority drop. The processor must issue these commands in the reverse order of the acknowledges. Any command that does not name the top entry is flagged and has no other effect. Deactivation is a separate command: the unit forwards it to the fabric and does not touch the running priority.

Top module: `irq_cpu_if`

## Requirements
- R1: Only the upper `PRI_BITS` bits of an offered priority are used and the lower bits are treated as zero. With the default of 4, the offered priorities 0x40 and 0x4F behave identically.
- R2: `irq_req` is high only if `hp_valid` is high and the effective priority is numerically strictly below `prio_mask`. Priority 0 is the most urgent.
- R3: The group priority is the effective priority with bits `bin_point` down to 0 cleared. `irq_req` additionally requires the group priority of the offer to be strictly below `run_prio`. `run_prio` is 0xFF while the stack is empty and is otherwise the group priority stored by the most recent acknowledge still on the stack. Equal group priorities never preempt.
- R4: An acknowledge on the port whose group matches `hp_group` (`hp_group`=0 for `ack0_req`, 1 for `ack1_req`), while `irq_req` is high, returns `hp_id` on `ack_id` in the same cycle. In the following cycle it pulses `act_valid` with `act_id` equal to that ID, and `run_prio` becomes the pushed group priority.
- R5: An acknowledge with nothing eligible, or on the port of the other group, returns 1023 on `ack_id`, gives no `act_valid` pulse and leaves `run_prio` unchanged. `ack_id` also reads 1023 while no acknowledge is requested.
- R6: An end-of-interrupt whose ID and group port match the top stack entry pops it, so `run_prio` returns to its value before that acknowledge. Popping every entry in reverse acknowledge order restores 0xFF.
- R7: An end-of-interrupt whose ID or group does not match the top entry, or that arrives with an empty stack, pulses `eoi_err` in the next cycle and leaves `run_prio` and the stack unchanged.
- R8: While the stack holds `STACK_DEPTH` entries, `irq_req` stays low whatever is offered, and acknowledges return 1023.
- R9: A deactivate command pulses `deact_valid` with `deact_id` equal to `dir_id` in the next cycle and does not change `run_prio`.
- R10: After reset `run_prio` is 0xFF, and `act_valid`, `eoi_err` and `deact_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hp_valid | input | 1 | The fabric offers a pending interrupt |
| hp_id | input | ID_W | ID of the offered interrupt |
| hp_prio | input | 8 | Priority of the offered interrupt |
| hp_group | input | 1 | Group of the offered interrupt (0 or 1) |
| prio_mask | input | 8 | Priority mask; only more urgent offers pass |
| bin_point | input | 3 | Binary point; bits at and below it are subpriority |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_group | output | 1 | Group of the requested interrupt |
| ack0_req | input | 1 | Acknowledge for group 0 |
| ack1_req | input | 1 | Acknowledge for group 1 |
| ack_id | output | ID_W | ID returned by the acknowledge, or 1023 |
| act_valid | output | 1 | Activation notice to the fabric |
| act_id | output | ID_W | ID being activated |
| eoi0_req | input | 1 | End of interrupt for group 0 |
| eoi1_req | input | 1 | End of interrupt for group 1 |
| eoi_id | input | ID_W | ID named by the end of interrupt |
| eoi_err | output | 1 | End of interrupt was out of order |
| dir_req | input | 1 | Deactivate command |
| dir_id | input | ID_W | ID to deactivate |
| deact_valid | output | 1 | Deactivation notice to the fabric |
| deact_id | output | ID_W | ID being deactivated |
| run_prio | output | 8 | Current running priority |

## Verification
The assertions assume that at most one of the two acknowledge and two end-of-interrupt strobes is high in any cycle. The assertions also assume the processor issues no end-of-interrupt or deactivate command during an acknowledge cycle. The bench drives all commands one at a time from tasks, and each command stands alone in its cycle. The offered interrupt, mask and binary point change only between commands. The sweeps vary them only while no strobe is active, so every eligibility check is made against a stable running priority.

// File: rtl/irq_cpu_if_pkg.sv
// Shared constants and types for the per-processor interrupt unit.
// Assumes 8-bit priorities, with a lower value meaning more urgent.
package irq_cpu_if_pkg;
    localparam int          PRIO_W     = 8;
    localparam logic [7:0]  PRIO_IDLE  = 8'hFF;
    localparam int          SPURIOUS   = 1023;

    typedef enum logic {
        GRP_ZERO = 1'b0,
        GRP_ONE  = 1'b1
    } irq_grp_e;
endpackage

// File: rtl/irq_prio_filter.sv
// Eligibility filter: truncates the offered priority to the implemented
// bits, derives its group priority from the binary point, and tests it
// against the priority mask, the running priority and stack capacity.
// Assumes that the inputs are stable within a cycle; purely combinational.
module irq_prio_filter
    import irq_cpu_if_pkg::*;
#(
    parameter int PRI_BITS = 4
) (
    input  logic              hp_valid,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [2:0]        bin_point,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    output logic              eligible,
    output logic [PRIO_W-1:0] grp_prio
);
    localparam logic [PRIO_W-1:0] IMPL_MASK = ~(8'hFF >> PRI_BITS);

    logic [PRIO_W-1:0] eff_prio;
    logic [PRIO_W-1:0] grp_mask;
    logic [3:0]        shift_amt;

    // Purpose: derive effective and group priority, then decide eligibility.
    always_comb begin
        eff_prio  = hp_prio & IMPL_MASK;
        shift_amt = {1'b0, bin_point} + 4'd1;
        grp_mask  = 8'hFF << shift_amt;
        grp_prio  = eff_prio & grp_mask;
        eligible  = hp_valid && (eff_prio < prio_mask) &&
                    (grp_prio < run_prio) && !stack_full;
    end
endmodule

// File: rtl/irq_run_stack.sv
// Running-priority stack: one entry per acknowledged interrupt still
// awaiting its priority drop. Pushes on acknowledge, pops on a matching
// end of interrupt. Assumes push and pop never occur in the same cycle and
// that the caller never pushes when full or pops when empty.
module irq_run_stack
    import irq_cpu_if_pkg::*;
#(
    parameter int ID_W  = 10,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_gprio,
    input  logic              push_grp,
    input  logic              pop,
    output logic [ID_W-1:0]   top_id,
    output logic              top_grp,
    output logic [PRIO_W-1:0] run_prio,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]  depth_q;
    logic [CNT_W-1:0]  top_sel;
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [PRIO_W-1:0] gp_q   [DEPTH];
    logic              grp_q  [DEPTH];

    // Purpose: track the number of live entries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            depth_q <= '0;
        else if (push && !full)
            depth_q <= depth_q + 1'b1;
        else if (pop && !empty)
            depth_q <= depth_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Purpose: capture an acknowledged interrupt into slot i when it is next free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_q[i]  <= '0;
                gp_q[i]  <= PRIO_IDLE;
                grp_q[i] <= 1'b0;
            end else if (push && depth_q == CNT_W'(i)) begin
                id_q[i]  <= push_id;
                gp_q[i]  <= push_gprio;
                grp_q[i] <= push_grp;
            end
        end
    end

    // Purpose: present the top entry and the running priority it implies.
    always_comb begin
        empty    = (depth_q == '0);
        full     = (depth_q == CNT_W'(DEPTH));
        top_sel  = depth_q - 1'b1;
        top_id   = id_q[top_sel[IDX_W-1:0]];
        top_grp  = grp_q[top_sel[IDX_W-1:0]];
        run_prio = empty ? PRIO_IDLE : gp_q[top_sel[IDX_W-1:0]];
    end

    // R4: an accepted push grows the stack by exactly one entry.
    a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> depth_q == $past(depth_q) + 1'b1);

    // R6: an accepted pop shrinks the stack by exactly one entry.
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> depth_q == $past(depth_q) - 1'b1);

    // R6: push and pop are never requested together.
    a_r6_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/irq_cpu_if.sv
// Per-processor interrupt unit: filters the fabric's best pending offer,
// raises the request, serves group-specific acknowledges and end of
// interrupt commands through a running-priority stack, and forwards
// deactivation separately. Assumes at most one acknowledge or end of
// interrupt strobe per cycle.
module irq_cpu_if
    import irq_cpu_if_pkg::*;
#(
    parameter int ID_W        = 10,
    parameter int PRI_BITS    = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [ID_W-1:0]   hp_id,
    input  logic [7:0]        hp_prio,
    input  logic              hp_group,
    input  logic [7:0]        prio_mask,
    input  logic [2:0]        bin_point,
    output logic              irq_req,
    output logic              irq_group,
    input  logic              ack0_req,
    input  logic              ack1_req,
    output logic [ID_W-1:0]   ack_id,
    output logic              act_valid,
    output logic [ID_W-1:0]   act_id,
    input  logic              eoi0_req,
    input  logic              eoi1_req,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              eoi_err,
    input  logic              dir_req,
    input  logic [ID_W-1:0]   dir_id,
    output logic              deact_valid,
    output logic [ID_W-1:0]   deact_id,
    output logic [7:0]        run_prio
);
    localparam logic [ID_W-1:0] SPUR_ID = ID_W'(SPURIOUS);

    logic              eligible;
    logic [PRIO_W-1:0] grp_prio;
    logic              stk_full;
    logic              stk_empty;
    logic [ID_W-1:0]   top_id;
    logic              top_grp;
    logic              ack_hit;
    logic              eoi_any;
    logic              eoi_grp;
    logic              eoi_match;
    logic              pop;

    irq_prio_filter #(
        .PRI_BITS (PRI_BITS)
    ) u_filter (
        .hp_valid   (hp_valid),
        .hp_prio    (hp_prio),
        .prio_mask  (prio_mask),
        .bin_point  (bin_point),
        .run_prio   (run_prio),
        .stack_full (stk_full),
        .eligible   (eligible),
        .grp_prio   (grp_prio)
    );

    irq_run_stack #(
        .ID_W  (ID_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ack_hit),
        .push_id    (hp_id),
        .push_gprio (grp_prio),
        .push_grp   (hp_group),
        .pop        (pop),
        .top_id     (top_id),
        .top_grp    (top_grp),
        .run_prio   (run_prio),
        .full       (stk_full),
        .empty      (stk_empty)
    );

    // Purpose: decode acknowledge and end of interrupt commands against the offer and stack top.
    always_comb begin
        irq_req   = eligible;
        irq_group = hp_group;
        ack_hit   = eligible && ((ack0_req && hp_group == GRP_ZERO) ||
                                 (ack1_req && hp_group == GRP_ONE));
        ack_id    = ack_hit ? hp_id : SPUR_ID;
        eoi_any   = eoi0_req || eoi1_req;
        eoi_grp   = eoi1_req;
        eoi_match = !stk_empty && (top_id == eoi_id) && (top_grp == eoi_grp);
        pop       = eoi_any && eoi_match;
    end

    // Purpose: register the activation, error and deactivation notices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid   <= 1'b0;
            act_id      <= '0;
            eoi_err     <= 1'b0;
            deact_valid <= 1'b0;
            deact_id    <= '0;
        end else begin
            act_valid   <= ack_hit;
            act_id      <= ack_hit ? hp_id : act_id;
            eoi_err     <= eoi_any && !eoi_match;
            deact_valid <= dir_req;
            deact_id    <= dir_req ? dir_id : deact_id;
        end
    end

    // Input assumption: one acknowledge or end of interrupt strobe per cycle.
    a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack0_req, ack1_req, eoi0_req, eoi1_req}));

    // R8: a full stack never lets a request through.
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !irq_req);

    // R5: an acknowledge without a request leaves the running priority alone.
    a_r5_spurious_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack0_req || ack1_req) && !irq_req && !dir_req) |=> run_prio == $past(run_prio));

    // R7: a flagged end of interrupt left the running priority unchanged.
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_any && !eoi_match) |=> (eoi_err && run_prio == $past(run_prio)));

    // R9: a deactivate command is forwarded one cycle later with its ID.
    a_r9_deact_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        dir_req |=> (deact_valid && deact_id == $past(dir_id)));

    // R3: with the stack empty the running priority is idle.
    a_r3_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> run_prio == PRIO_IDLE);
endmodule

// File: tb/test_irq_cpu_if.sv
module test_irq_cpu_if;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 10;
    localparam int PB    = 4;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            hp_valid, hp_group;
    logic [ID_W-1:0] hp_id;
    logic [7:0]      hp_prio, prio_mask;
    logic [2:0]      bin_point;
    logic            irq_req, irq_group;
    logic            ack0_req, ack1_req, eoi0_req, eoi1_req, dir_req;
    logic [ID_W-1:0] ack_id, act_id, eoi_id, dir_id, deact_id;
    logic            act_valid, eoi_err, deact_valid;
    logic [7:0]      run_prio;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_id  [DEPTH];
    int m_gp  [DEPTH];
    int m_grp [DEPTH];
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cpu_if #(.ID_W(ID_W), .PRI_BITS(PB), .STACK_DEPTH(DEPTH)) i_irq_cpu_if (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id),
        .hp_prio(hp_prio), .hp_group(hp_group), .prio_mask(prio_mask),
        .bin_point(bin_point), .irq_req(irq_req), .irq_group(irq_group),
        .ack0_req(ack0_req), .ack1_req(ack1_req), .ack_id(ack_id),
        .act_valid(act_valid), .act_id(act_id), .eoi0_req(eoi0_req),
        .eoi1_req(eoi1_req), .eoi_id(eoi_id), .eoi_err(eoi_err),
        .dir_req(dir_req), .dir_id(dir_id), .deact_valid(deact_valid),
        .deact_id(deact_id), .run_prio(run_prio)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int p);
        return p & ((8'hFF << (8 - PB)) & 8'hFF);
    endfunction

    function automatic int gprio(input int p, input int b);
        return eff(p) & ((9'h1FF << (b + 1)) & 8'hFF);
    endfunction

    function automatic int m_rpr();
        return (m_cnt == 0) ? 255 : m_gp[m_cnt-1];
    endfunction

    function automatic bit m_elig(input int p, input int pm, input int b);
        return hp_valid && (eff(p) < pm) && (gprio(p, b) < m_rpr()) && (m_cnt < DEPTH);
    endfunction

    task automatic offer(input int id, input int p, input int g);
        hp_valid = 1'b1; hp_id = ID_W'(id); hp_prio = 8'(p); hp_group = g[0];
    endtask

    // Acknowledge on port g; model decides expected ID and push.
    task automatic do_ack(input int g, input string req);
        bit hit;
        int exp_id;
        @(negedge clk);
        hit = m_elig(hp_prio, prio_mask, bin_point) && (hp_group == g[0]);
        exp_id = hit ? int'(hp_id) : 1023;
        if (g == 0) ack0_req = 1'b1; else ack1_req = 1'b1;
        #1;
        chk(ack_id == ID_W'(exp_id), req, ack_id, exp_id);
        @(negedge clk);
        ack0_req = 1'b0; ack1_req = 1'b0;
        #1;
        chk(act_valid == hit, req, act_valid, hit);
        if (hit) begin
            chk(act_id == ID_W'(exp_id), req, act_id, exp_id);
            m_id[m_cnt] = exp_id; m_gp[m_cnt] = gprio(hp_prio, bin_point);
            m_grp[m_cnt] = g; m_cnt++;
        end
        chk(run_prio == 8'(m_rpr()), req, run_prio, m_rpr());
    endtask

    task automatic do_eoi(input int g, input int id, input string req);
        bit ok;
        @(negedge clk);
        ok = (m_cnt > 0) && (m_id[m_cnt-1] == id) && (m_grp[m_cnt-1] == g);
        eoi_id = ID_W'(id);
        if (g == 0) eoi0_req = 1'b1; else eoi1_req = 1'b1;
        @(negedge clk);
        eoi0_req = 1'b0; eoi1_req = 1'b0;
        if (ok) m_cnt--;
        #1;
        chk(eoi_err == !ok, req, eoi_err, !ok);
        chk(run_prio == 8'(m_rpr()), req, run_prio, m_rpr());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hp_valid = 0; hp_id = '0; hp_prio = '0; hp_group = 0;
        prio_mask = 8'hFF; bin_point = 3'd0;
        ack0_req = 0; ack1_req = 0; eoi0_req = 0; eoi1_req = 0; dir_req = 0;
        eoi_id = '0; dir_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state.
        chk(run_prio == 8'hFF, "R10 rpr", run_prio, 255);
        chk(!act_valid && !eoi_err && !deact_valid, "R10 pulses", {act_valid, eoi_err, deact_valid}, 0);
        chk(ack_id == 10'd1023, "R5 idle ack_id", ack_id, 1023);

        // R1/R2: mask sweep over every priority with an empty stack.
        foreach (m_id[k]) m_id[k] = 0;
        for (int pmi = 0; pmi < 6; pmi++) begin
            int pm;
            pm = (pmi == 0) ? 0 : (pmi == 1) ? 8'h40 : (pmi == 2) ? 8'h4F :
                 (pmi == 3) ? 8'h80 : (pmi == 4) ? 8'hF0 : 8'hFF;
            for (int p = 0; p < 256; p++) begin
                @(negedge clk);
                prio_mask = 8'(pm); offer(7, p, 0);
                #1;
                chk(irq_req == m_elig(p, pm, 0), "R1 R2 mask sweep", irq_req, m_elig(p, pm, 0));
            end
        end

        // R2: no request without a valid offer.
        @(negedge clk); hp_valid = 0; prio_mask = 8'hFF; #1;
        chk(!irq_req, "R2 invalid offer", irq_req, 0);
        do_ack(0, "R5 ack with nothing pending");

        // R3/R4: acknowledge priority 0x80, then sweep binary point and offers.
        offer(20, 8'h8C, 1);
        do_ack(1, "R4 ack first");
        chk(run_prio == 8'h80, "R4 rpr after ack", run_prio, 128);
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 256; p++) begin
                @(negedge clk);
                bin_point = 3'(b); offer(21, p, 0);
                #1;
                chk(irq_req == m_elig(p, 255, b), "R3 preempt sweep", irq_req, m_elig(p, 255, b));
            end
        end
        @(negedge clk); bin_point = 3'd0;

        // R4/R6/R7/R8: nest up to the stack depth, then unwind.
        offer(41, 8'h60, 0); do_ack(0, "R4 nest two");
        offer(42, 8'h40, 1); do_ack(0, "R5 wrong group port");
        do_ack(1, "R4 nest three");
        offer(43, 8'h20, 1); do_ack(1, "R4 nest four");
        @(negedge clk); offer(44, 8'h00, 0); #1;
        chk(!irq_req, "R8 full blocks request", irq_req, 0);
        do_ack(0, "R8 ack while full");
        do_eoi(1, 20, "R7 out of order id");
        do_eoi(0, 43, "R7 wrong group port");
        do_eoi(1, 43, "R6 pop four");
        do_eoi(1, 42, "R6 pop three");
        // R9: deactivation forwarded, running priority untouched.
        @(negedge clk); dir_req = 1; dir_id = 10'd41;
        @(negedge clk); dir_req = 0; #1;
        chk(deact_valid && deact_id == 10'd41, "R9 deactivate", deact_id, 41);
        chk(run_prio == 8'(m_rpr()), "R9 rpr unchanged", run_prio, m_rpr());
        do_eoi(0, 41, "R6 pop two");
        do_eoi(1, 20, "R6 pop one");
        chk(run_prio == 8'hFF, "R6 idle restored", run_prio, 255);
        do_eoi(0, 20, "R7 empty stack");

        // R3: equal group priority does not preempt.
        @(negedge clk); bin_point = 3'd4; offer(50, 8'h40, 0);
        do_ack(0, "R4 ack for equal group test");
        @(negedge clk); offer(51, 8'h50, 0); #1;
        chk(!irq_req, "R3 equal group no preempt", irq_req, 0);
        @(negedge clk); offer(52, 8'h20, 0); #1;
        chk(irq_req, "R3 higher group preempts", irq_req, 1);
        do_eoi(0, 50, "R6 final pop");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule